// File: doc/BRIEF.md
# Interleaving Stream Reorder Buffer

This block sits in front of a recurrence pipeline that solves many tridiagonal systems at once. Rows arrive system by system: every row of one system comes in before the first row of the next. The block collects a group of `GRP` systems of `ROWS` rows each, then emits the group row-interleaved. Row 0 of every system in the group comes out first, then row 1 of every system, and so on. A downstream pipeline then sees consecutive words from different systems, so its loop-carried dependency is `GRP` words apart instead of one.

Both sides are valid/ready streams of `DATA_W`-bit words (256 by default). A word holds several floating-point lanes, and the block moves it through untouched. The storage has two banks, each holding one group. While one bank is filled, the other is drained. A bank is read only once it is completely written, and it is refilled only once it is completely read. A run covers `NUM_GRP` groups and uses a single unbroken count, so a bank swap costs no cycles. When the last group has been accepted, the input stays closed until the next reset.

Top module: `ilv_reorder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0. Any data in flight is dropped, and the next accepted word starts group 0 again.
- R2: Input word j of a run belongs to group j/(GRP*ROWS), system (j mod GRP*ROWS)/ROWS and row j mod ROWS. Output word n is taken from group n/(GRP*ROWS), row r/GRP and system r mod GRP, where r = n mod GRP*ROWS. So output word n equals input word (group*GRP + system)*ROWS + row.
- R3: Every bit of every lane of a word reaches `out_data` unchanged.
- R4: `out_valid` stays 0 until all GRP*ROWS words of a group have been accepted. It is 1 in the cycle right after the handshake of the group's last word.
- R5: With `out_ready` held low, exactly 2*GRP*ROWS words are accepted and then `in_ready` stays 0. `in_ready` returns to 1 in the cycle after the last word of the drained bank is read, and not before.
- R6: With `in_valid` and `out_ready` held high, `in_ready` does not drop during a run. Outputs leave on consecutive cycles with no gap, including across bank swaps. The first output transfer comes GRP*ROWS cycles after the first input transfer.
- R7: After NUM_GRP*GRP*ROWS words have been accepted, `in_ready` stays 0 and further `in_valid` has no effect. Once the last word has left, `out_valid` is 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | DATA_W | Input word, system-major order |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Output word, row-interleaved order |

## Verification
`in_ready` and `out_valid` come only from registers. A handshake at one clock edge shows up in these flags in the cycle that follows. The last write of a group therefore raises `out_valid` one cycle later, and the last read of a bank raises `in_ready` one cycle later. The bench drives inputs just after the rising edge and samples on the falling edge. It time-stamps each input and output transfer with the count of rising edges. From these stamps it checks that the first output trails the first input by exactly GRP*ROWS cycles, and that the outputs of a run show no gap.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   // width of a counter that takes the values 0 .. n-1
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // true when n is a power of two of at least 2
   function automatic bit is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/ilv_addr.sv
module ilv_addr
   import ilv_pkg::*;
#(
   parameter int unsigned GRP  = 4,
   parameter int unsigned ROWS = 8,
   localparam int unsigned SYS_W = cnt_w(GRP),
   localparam int unsigned ROW_W = cnt_w(ROWS),
   localparam int unsigned AW    = cnt_w(GRP * ROWS)
) (
   input  logic [SYS_W-1:0] sys,
   input  logic [ROW_W-1:0] row,
   output logic [AW-1:0]    addr
);
   // bank-local slot of (system, row): system*ROWS + row
   generate
      if (is_pow2(ROWS)) begin : g_concat
         logic [SYS_W+ROW_W-1:0] cat;
         assign cat  = {sys, row};
         assign addr = AW'(cat);
      end else begin : g_mul
         int unsigned slot;
         assign slot = int'(sys) * ROWS + int'(row);
         assign addr = AW'(slot);
      end
   endgenerate
endmodule

// File: rtl/ilv_side_ctrl.sv
module ilv_side_ctrl
   import ilv_pkg::*;
#(
   parameter int unsigned GRP       = 4,
   parameter int unsigned ROWS      = 8,
   parameter int unsigned NUM_GRP   = 3,
   parameter bit          SYS_INNER = 1'b0,
   localparam int unsigned SYS_W = cnt_w(GRP),
   localparam int unsigned ROW_W = cnt_w(ROWS),
   localparam int unsigned GRP_W = cnt_w(NUM_GRP)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [SYS_W-1:0] sys,
   output logic [ROW_W-1:0] row,
   output logic             bank,
   output logic             bank_last,
   output logic             done
);
   logic             sys_end, row_end, sys_inc, row_inc, grp_inc;
   logic [GRP_W-1:0] grp;

   assign sys_end   = (sys == SYS_W'(GRP - 1));
   assign row_end   = (row == ROW_W'(ROWS - 1));
   assign bank_last = sys_end && row_end;
   assign grp_inc   = step && bank_last;

   // nesting order picks the traversal: rows inner (writer) or systems inner (reader)
   generate
      if (SYS_INNER) begin : g_sys_inner
         always_comb begin
            sys_inc = step;
            row_inc = step && sys_end;
         end
      end else begin : g_row_inner
         always_comb begin
            row_inc = step;
            sys_inc = step && row_end;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sys  <= '0;
         row  <= '0;
         grp  <= '0;
         bank <= 1'b0;
         done <= 1'b0;
      end else begin
         if (sys_inc) sys <= sys_end ? '0 : sys + 1'b1;
         if (row_inc) row <= row_end ? '0 : row + 1'b1;
         if (grp_inc) begin
            bank <= ~bank;
            if (grp == GRP_W'(NUM_GRP - 1)) begin
               grp  <= '0;
               done <= 1'b1;
            end else begin
               grp <= grp + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
   parameter int unsigned DATA_W = 256,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned AW     = 5
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ilv_reorder.sv
module ilv_reorder
   import ilv_pkg::*;
#(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned GRP     = 4,
   parameter int unsigned ROWS    = 8,
   parameter int unsigned NUM_GRP = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int unsigned DEPTH = GRP * ROWS;
   localparam int unsigned SYS_W = cnt_w(GRP);
   localparam int unsigned ROW_W = cnt_w(ROWS);
   localparam int unsigned AW    = cnt_w(DEPTH);

   generate
      if (GRP < 1)     begin : g_bad_grp  $error("GRP must be at least 1");     end
      if (ROWS < 1)    begin : g_bad_rows $error("ROWS must be at least 1");    end
      if (NUM_GRP < 1) begin : g_bad_num  $error("NUM_GRP must be at least 1"); end
      if (DATA_W < 1)  begin : g_bad_w    $error("DATA_W must be at least 1");  end
   endgenerate

   logic             wr_step, rd_step;
   logic [SYS_W-1:0] w_sys, r_sys;
   logic [ROW_W-1:0] w_row, r_row;
   logic             w_bank, r_bank, w_last, r_last, w_done, r_done;
   logic [AW-1:0]    w_addr, r_addr;
   logic [1:0]       full;
   logic [DATA_W-1:0] bank_rd [2];

   assign in_ready  = !full[w_bank] && !w_done;
   assign out_valid = full[r_bank] && !r_done;
   assign wr_step   = in_valid && in_ready;
   assign rd_step   = out_valid && out_ready;

   ilv_side_ctrl #(.GRP(GRP), .ROWS(ROWS), .NUM_GRP(NUM_GRP), .SYS_INNER(1'b0)) u_wr (
      .clk(clk), .rst(rst), .step(wr_step), .sys(w_sys), .row(w_row),
      .bank(w_bank), .bank_last(w_last), .done(w_done)
   );

   ilv_side_ctrl #(.GRP(GRP), .ROWS(ROWS), .NUM_GRP(NUM_GRP), .SYS_INNER(1'b1)) u_rd (
      .clk(clk), .rst(rst), .step(rd_step), .sys(r_sys), .row(r_row),
      .bank(r_bank), .bank_last(r_last), .done(r_done)
   );

   ilv_addr #(.GRP(GRP), .ROWS(ROWS)) u_waddr (.sys(w_sys), .row(w_row), .addr(w_addr));
   ilv_addr #(.GRP(GRP), .ROWS(ROWS)) u_raddr (.sys(r_sys), .row(r_row), .addr(r_addr));

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         logic we_b;
         assign we_b = wr_step && (w_bank == 1'(b));

         ilv_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
            .clk(clk), .we(we_b), .waddr(w_addr), .wdata(in_data),
            .raddr(r_addr), .rdata(bank_rd[b])
         );

         always_ff @(posedge clk) begin
            if (rst) begin
               full[b] <= 1'b0;
            end else if (wr_step && w_last && (w_bank == 1'(b))) begin
               full[b] <= 1'b1;
            end else if (rd_step && r_last && (r_bank == 1'(b))) begin
               full[b] <= 1'b0;
            end
         end
      end
   endgenerate

   assign out_data = bank_rd[r_bank];
endmodule

// File: rtl/ilv_reorder_chk.sv
module ilv_reorder_chk
   import ilv_pkg::*;
#(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned GRP     = 4,
   parameter int unsigned ROWS    = 8,
   parameter int unsigned NUM_GRP = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   localparam int unsigned DEPTH = GRP * ROWS;
   localparam int unsigned TOTAL = DEPTH * NUM_GRP;
   localparam int unsigned OCC_W = cnt_w(2 * DEPTH + 2);
   localparam int unsigned TIN_W = cnt_w(TOTAL + 2);

   logic [OCC_W-1:0] occ;
   logic [TIN_W-1:0] tin;
   logic             acc, emit;

   assign acc  = in_valid && in_ready;
   assign emit = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         occ <= '0;
         tin <= '0;
      end else begin
         occ <= occ + OCC_W'(acc) - OCC_W'(emit);
         if (acc) tin <= tin + 1'b1;
      end
   end

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_ready && !out_valid));                                   // R1
   AST_READ_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> (occ >= OCC_W'(DEPTH)));                               // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      occ <= OCC_W'(2 * DEPTH));                                                  // R5
   AST_OUT_GAPLESS: assert property (@(posedge clk) disable iff (rst)
      (emit && occ > OCC_W'(DEPTH)) |=> out_valid);                               // R6
   AST_IN_GAPLESS: assert property (@(posedge clk) disable iff (rst)
      (acc && occ < OCC_W'(DEPTH) && tin != TIN_W'(TOTAL - 1)) |=> in_ready);     // R6
   AST_BATCH_CLOSED: assert property (@(posedge clk) disable iff (rst)
      (tin == TIN_W'(TOTAL)) |-> !in_ready);                                      // R7
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));            // R8
endmodule

bind ilv_reorder ilv_reorder_chk #(
   .DATA_W(DATA_W), .GRP(GRP), .ROWS(ROWS), .NUM_GRP(NUM_GRP)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/ilv_reorder_bench.sv
`timescale 1ns/1ps
module ilv_reorder_bench;
   localparam int DATA_W  = 256;
   localparam int GRP     = 4;
   localparam int ROWS    = 8;
   localparam int NUM_GRP = 3;
   localparam int DEPTH   = GRP * ROWS;
   localparam int TOTAL   = DEPTH * NUM_GRP;
   localparam int LANES   = DATA_W / 32;
   localparam int WD_LIMIT = 20000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   int in_first, in_stall, in_idx;
   int mon_cnt, mon_err, mon_first, mon_last, hold_err;
   logic hold_v;
   logic [DATA_W-1:0] hold_d;

   always #2 clk = ~clk;

   ilv_reorder #(.DATA_W(DATA_W), .GRP(GRP), .ROWS(ROWS), .NUM_GRP(NUM_GRP)) u_ilv_reorder (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   // every lane of a word carries a distinct pattern derived from its tag
   function automatic logic [DATA_W-1:0] mk_word(input int tag);
      logic [DATA_W-1:0] w;
      for (int l = 0; l < LANES; l++)
         w[32*l +: 32] = (32'(tag) * 32'd8 + 32'(l)) ^ 32'h5A3C_0000 ^ (32'(l) << 24);
      return w;
   endfunction

   // input tag expected at output position n (R2)
   function automatic int exp_tag(input int n);
      int g, r, i, k;
      g = n / DEPTH;
      r = n % DEPTH;
      i = r / GRP;
      k = r % GRP;
      return g * DEPTH + k * ROWS + i;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // output monitor: sampled on the falling edge, transfer occurs at the next rising edge
   always @(negedge clk) begin
      if (rst) begin
         mon_cnt = 0; mon_err = 0; mon_first = -1; mon_last = 0;
         hold_err = 0; hold_v = 1'b0;
      end else begin
         if (hold_v && (!out_valid || out_data != hold_d)) hold_err++;
         hold_v = out_valid && !out_ready;
         hold_d = out_data;
         if (out_valid && out_ready) begin
            if (out_data != mk_word(exp_tag(mon_cnt))) mon_err++;
            if (mon_first < 0) mon_first = cyc;
            mon_last = cyc;
            mon_cnt++;
         end
      end
   end

   task automatic do_reset();
      @(posedge clk); #1;
      rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
      in_idx = 0; in_stall = 0; in_first = -1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   // presents the next input word and returns 1 ns after the edge that accepted it
   task automatic push_one();
      in_valid = 1'b1;
      in_data  = mk_word(in_idx);
      @(negedge clk);
      while (!in_ready) begin
         in_stall++;
         @(negedge clk);
      end
      if (in_first < 0) in_first = cyc;
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_idx++;
   endtask

   task automatic wait_out(input int n);
      while (mon_cnt < n) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      @(negedge clk);
      chk("R1", "in_ready after reset", int'(in_ready), 1);
      chk("R1", "out_valid after reset", int'(out_valid), 0);
   endtask

   task automatic t_fill_gate();
      do_reset();
      out_ready = 1'b1;
      for (int j = 0; j < DEPTH - 1; j++) push_one();
      repeat (3) @(posedge clk);
      #1;
      chk("R4", "out_valid with one word missing", int'(out_valid), 0);
      push_one();
      chk("R4", "out_valid after last word of group", int'(out_valid), 1);
      wait_out(DEPTH);
      chk("R2", "group 0 order errors", mon_err, 0);
   endtask

   task automatic t_full_rate();
      do_reset();
      out_ready = 1'b1;
      for (int j = 0; j < TOTAL; j++) push_one();
      wait_out(TOTAL);
      chk("R2", "order errors at full rate", mon_err, 0);
      chk("R3", "words out", mon_cnt, TOTAL);
      chk("R6", "input stall cycles", in_stall, 0);
      chk("R6", "output gap cycles", (mon_last - mon_first + 1) - mon_cnt, 0);
      chk("R6", "first output latency", mon_first - in_first, DEPTH);
      // R7: the run is closed; further valid words are refused
      in_valid = 1'b1;
      in_data  = mk_word(999);
      repeat (4) begin
         @(negedge clk);
         chk("R7", "in_ready after full run", int'(in_ready), 0);
      end
      chk("R7", "out_valid after full run", int'(out_valid), 0);
      chk("R7", "extra words emitted", mon_cnt, TOTAL);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic t_bank_block();
      int seen_early;
      do_reset();
      out_ready = 1'b0;
      for (int j = 0; j < 2 * DEPTH; j++) push_one();
      chk("R5", "stalls while two banks fill", in_stall, 0);
      in_valid = 1'b1;
      in_data  = mk_word(in_idx);
      repeat (3) @(posedge clk);
      #1;
      chk("R5", "in_ready with both banks full", int'(in_ready), 0);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      seen_early = 0;
      while (mon_cnt < DEPTH) begin
         @(posedge clk); #1;
         if (mon_cnt < DEPTH && in_ready) seen_early++;
      end
      chk("R5", "in_ready before bank drained", seen_early, 0);
      chk("R5", "in_ready after bank drained", int'(in_ready), 1);
      for (int j = 0; j < DEPTH; j++) push_one();
      wait_out(TOTAL);
      chk("R2", "order errors after blocking", mon_err, 0);
   endtask

   task automatic t_backpressure();
      do_reset();
      fork
         begin
            for (int j = 0; j < TOTAL; j++) begin
               push_one();
               for (int q = 0; q < (j % 3); q++) begin
                  @(posedge clk); #1;
               end
            end
         end
         begin
            while (mon_cnt < TOTAL) begin
               @(posedge clk); #1;
               out_ready = ((cyc % 5) != 1) && ((cyc % 7) != 3);
            end
         end
      join
      out_ready = 1'b1;
      chk("R2", "order errors with gaps and backpressure", mon_err, 0);
      chk("R8", "hold violations", hold_err, 0);
   endtask

   task automatic t_mid_reset();
      do_reset();
      out_ready = 1'b1;
      for (int j = 0; j < DEPTH + 9; j++) push_one();
      do_reset();
      @(negedge clk);
      chk("R1", "out_valid after mid-run reset", int'(out_valid), 0);
      chk("R1", "in_ready after mid-run reset", int'(in_ready), 1);
      @(posedge clk); #1;
      out_ready = 1'b1;
      for (int j = 0; j < TOTAL; j++) push_one();
      wait_out(TOTAL);
      chk("R1", "order errors after mid-run reset", mon_err, 0);
   endtask

   initial begin
      t_reset_state();
      t_fill_gate();
      t_full_rate();
      t_bank_block();
      t_backpressure();
      t_mid_reset();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule